// File: doc/BRIEF.md
# Battery-Monitor Memory Command Controller

This block is the byte-level command layer of a battery-monitor slave on a single-wire serial link. Framing and bit timing are handled upstream. The block receives a stream of decoded bytes: an opcode, an optional start address, and then data. It serves reads and writes of three 32-byte scratchpad pages. It moves whole pages between each scratchpad and its backing store: two nonvolatile pages and one SRAM page.

It also performs these functions:
- It write-protects the leading bytes of the first scratchpad and nonvolatile page.
- It keeps a cycle counter that can be cleared or incremented.
- It starts voltage and temperature conversions on external converters and latches their results.
- It presents a small register window holding the measurements, a status byte, the counter and an identity value.

Nonvolatile programming is modelled as a fixed cycle delay. The converters are modelled as a start pulse answered by a done strobe that carries the result.

Top module: `bm_cmd_engine`

## Requirements
- R1: Opcode 17h, then a start address in 00h–5Fh, writes each following received byte to the scratchpad and advances the address by one. Opcode 11h, then an address, answers each read request with the scratchpad byte and advances the address by one. The pages are 32 bytes at 00h, 20h and 40h.
- R2: A start address outside the allowed range, or an increment that leaves it, ends the transaction. Reads then return FFh and writes have no effect until a bus reset. For opcodes 11h and 17h the range is 00h–5Fh. For opcode B2h it is the register window of R6.
- R3: Opcode 22h copies scratchpad page 1 into nonvolatile page 1. Opcode 25h copies page 2 into nonvolatile page 2. The copy takes effect at the end of the nonvolatile delay. The busy output `nv_busy_o` is 1 for exactly NV_DELAY cycles, starting the cycle after the opcode.
- R4: Three opcodes copy immediately into a scratchpad: 71h from nonvolatile page 1 into page 1, 77h from nonvolatile page 2 into page 2, and 7Ah from SRAM into page 3. Opcode 28h immediately copies page 3 into SRAM.
- R5: Opcode 43h locks offsets 0..LOCK_BYTES-1 of scratchpad page 1 and nonvolatile page 1, and 44h unlocks them. Each takes effect at the end of the nonvolatile delay. Writes into locked bytes, by scratchpad write or by any copy, are discarded. Status bit 3 shows the lock.
- R6: Opcode B2h, then an address, reads the register window with auto-increment:
  - 60h/61h: temperature, low then high byte.
  - 62h/63h: voltage, low then high byte.
  - 77h: status, with bit0 nonvolatile busy, bit1 voltage busy, bit2 temperature busy, bit3 locked.
  - 78h, 82h, 83h: DEV_ID bits 7:0, 15:8 and 23:16.
  - 80h/81h: cycle counter, low then high byte.
- R7: Opcode B8h clears the cycle counter and B5h increments it. Each takes effect at the end of the nonvolatile delay.
- R8: While `nv_busy_o` is 1, the opcodes 22h, 25h, 43h, 44h, B5h and B8h are ignored.
- R9: Opcode B4h pulses `v_conv_go_o` for one cycle and sets `v_busy_o`. Opcode D2h does the same with `t_conv_go_o` and `t_busy_o`. The matching done strobe clears the flag and latches the result into the register window.
- R10: An unknown opcode makes the block ignore all bytes until a bus reset. Reads return FFh in that state.
- R11: After reset the following are all zero: all pages, the counter, the lock state and the three busy flags.
- R12: Every read request is answered by `rd_vld_o` in the next cycle. The byte is FFh whenever no read transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset indication; returns to opcode phase |
| rx_vld_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for the next read byte |
| rd_vld_o | output | 1 | Read byte valid |
| rd_byte_o | output | 8 | Read byte |
| v_conv_go_o | output | 1 | Voltage conversion start pulse |
| v_conv_done_i | input | 1 | Voltage conversion done strobe |
| v_conv_data_i | input | 16 | Voltage result |
| t_conv_go_o | output | 1 | Temperature conversion start pulse |
| t_conv_done_i | input | 1 | Temperature conversion done strobe |
| t_conv_data_i | input | 16 | Temperature result |
| nv_busy_o | output | 1 | Nonvolatile operation in progress |
| v_busy_o | output | 1 | Voltage conversion in progress |
| t_busy_o | output | 1 | Temperature conversion in progress |

## Verification
The scratchpad path is swept over every one of its 96 addresses with two different arithmetic patterns. This separates address decoding and auto-increment faults from data faults. Reads and writes that start near 5Fh and at the window edges show where a transaction stops. The page copies are tested in both directions between two distinct patterns, so a copy that is missing or sent to the wrong page shows up as the wrong pattern. Lock, counter, conversion and unknown-opcode sequences are each replayed, and the outcome is read back through the read path.

// File: rtl/bm_pkg.sv
package bm_pkg;
   localparam logic [7:0] OPC_RD_SP   = 8'h11;
   localparam logic [7:0] OPC_WR_SP   = 8'h17;
   localparam logic [7:0] OPC_SP1_NV1 = 8'h22;
   localparam logic [7:0] OPC_SP2_NV2 = 8'h25;
   localparam logic [7:0] OPC_SP3_RAM = 8'h28;
   localparam logic [7:0] OPC_NV1_SP1 = 8'h71;
   localparam logic [7:0] OPC_NV2_SP2 = 8'h77;
   localparam logic [7:0] OPC_RAM_SP3 = 8'h7A;
   localparam logic [7:0] OPC_LOCK    = 8'h43;
   localparam logic [7:0] OPC_UNLOCK  = 8'h44;
   localparam logic [7:0] OPC_RD_REG  = 8'hB2;
   localparam logic [7:0] OPC_CNT_CLR = 8'hB8;
   localparam logic [7:0] OPC_CNT_INC = 8'hB5;
   localparam logic [7:0] OPC_CONV_V  = 8'hB4;
   localparam logic [7:0] OPC_CONV_T  = 8'hD2;

   localparam int PG_BYTES = 32;
   localparam int NUM_SP   = 3;
   localparam int SP_BYTES = PG_BYTES * NUM_SP;

   typedef enum logic [2:0] {ST_OPC, ST_ADDR, ST_XFER, ST_HALT} state_e;
   typedef enum logic [1:0] {XK_SP_RD, XK_SP_WR, XK_REG_RD} xfer_e;
   typedef enum logic [2:0] {NV_CP1, NV_CP2, NV_LOCK, NV_UNLOCK, NV_CCLR, NV_CINC} nvop_e;

   function automatic logic sp_addr_ok(input logic [7:0] a);
      return a < 8'(SP_BYTES);
   endfunction

   function automatic logic reg_addr_ok(input logic [7:0] a);
      return (a >= 8'h60 && a <= 8'h63) || a == 8'h77 || a == 8'h78 ||
             (a >= 8'h80 && a <= 8'h83);
   endfunction

   function automatic logic is_nv_opc(input logic [7:0] b);
      return b == OPC_SP1_NV1 || b == OPC_SP2_NV2 || b == OPC_LOCK ||
             b == OPC_UNLOCK || b == OPC_CNT_CLR || b == OPC_CNT_INC;
   endfunction
endpackage

// File: rtl/bm_nv_timer.sv
module bm_nv_timer #(
   parameter int DELAY = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(DELAY + 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("bm_nv_timer: DELAY must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt_q  <= CW'(DELAY);
      end else if (busy_o) begin
         if (cnt_q == CW'(1)) busy_o <= 1'b0;
         else                 cnt_q  <= cnt_q - CW'(1);
      end
   end

   assign done_o = busy_o && (cnt_q == CW'(1));

   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
endmodule

// File: rtl/bm_conv_chan.sv
module bm_conv_chan #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          done_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic [DW-1:0] val_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         val_o  <= '0;
      end else if (busy_o && done_i) begin
         busy_o <= 1'b0;
         val_o  <= data_i;
      end else if (go_i) begin
         busy_o <= 1'b1;
      end
   end

   // R9
   hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_i) |=> busy_o);
   // R9
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && done_i) |=> (!busy_o && val_o == $past(data_i)));
endmodule

// File: rtl/bm_cmd_engine.sv
module bm_cmd_engine
   import bm_pkg::*;
#(
   parameter int          NV_DELAY   = 200000,
   parameter int          LOCK_BYTES = 24,
   parameter int          CNT_W      = 16,
   parameter logic [23:0] DEV_ID     = 24'hA5C3E1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_rst_i,
   input  logic        rx_vld_i,
   input  logic [7:0]  rx_byte_i,
   input  logic        rd_req_i,
   output logic        rd_vld_o,
   output logic [7:0]  rd_byte_o,
   output logic        v_conv_go_o,
   input  logic        v_conv_done_i,
   input  logic [15:0] v_conv_data_i,
   output logic        t_conv_go_o,
   input  logic        t_conv_done_i,
   input  logic [15:0] t_conv_data_i,
   output logic        nv_busy_o,
   output logic        v_busy_o,
   output logic        t_busy_o
);
   localparam int NCH  = 2;
   localparam int CH_V = 0;
   localparam int CH_T = 1;

   if (LOCK_BYTES < 0 || LOCK_BYTES > PG_BYTES) begin : g_bad_lock
      $error("bm_cmd_engine: LOCK_BYTES out of page range");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("bm_cmd_engine: CNT_W must be 1..16");
   end

   state_e           state_q;
   xfer_e            kind_q;
   nvop_e            pend_q;
   logic [7:0]       addr_q;
   logic             lock_q;
   logic [CNT_W-1:0] cyc_q;
   logic [7:0]       sp_q   [SP_BYTES];
   logic [7:0]       nv1_q  [PG_BYTES];
   logic [7:0]       nv2_q  [PG_BYTES];
   logic [7:0]       ram_q  [PG_BYTES];
   logic [PG_BYTES-1:0] lk_mask;
   logic [NCH-1:0]   conv_go, conv_go_q, conv_done, conv_busy;
   logic [15:0]      conv_din [NCH];
   logic [15:0]      conv_val [NCH];
   logic             nv_start, nv_done, opc_take;
   logic [7:0]       reg_byte, status_b;
   logic [15:0]      cyc16;
   logic [7:0]       addr_nx;

   for (genvar g = 0; g < PG_BYTES; g++) begin : g_lock_mask
      assign lk_mask[g] = (g < LOCK_BYTES);
   end

   assign opc_take = (state_q == ST_OPC) && rx_vld_i && !bus_rst_i;
   assign nv_start = opc_take && is_nv_opc(rx_byte_i) && !nv_busy_o;
   assign addr_nx  = addr_q + 8'd1;

   bm_nv_timer #(.DELAY(NV_DELAY)) u_nv_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (nv_start),
      .busy_o  (nv_busy_o),
      .done_o  (nv_done)
   );

   assign conv_go[CH_V]   = opc_take && rx_byte_i == OPC_CONV_V;
   assign conv_go[CH_T]   = opc_take && rx_byte_i == OPC_CONV_T;
   assign conv_done[CH_V] = v_conv_done_i;
   assign conv_done[CH_T] = t_conv_done_i;
   assign conv_din[CH_V]  = v_conv_data_i;
   assign conv_din[CH_T]  = t_conv_data_i;

   for (genvar c = 0; c < NCH; c++) begin : g_conv
      bm_conv_chan #(.DW(16)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .go_i   (conv_go[c]),
         .done_i (conv_done[c]),
         .data_i (conv_din[c]),
         .busy_o (conv_busy[c]),
         .val_o  (conv_val[c])
      );
   end

   assign v_busy_o    = conv_busy[CH_V];
   assign t_busy_o    = conv_busy[CH_T];
   assign v_conv_go_o = conv_go_q[CH_V];
   assign t_conv_go_o = conv_go_q[CH_T];

   assign status_b = {4'd0, lock_q, t_busy_o, v_busy_o, nv_busy_o};
   assign cyc16    = 16'(cyc_q);

   always_comb begin
      case (addr_q)
         8'h60:   reg_byte = conv_val[CH_T][7:0];
         8'h61:   reg_byte = conv_val[CH_T][15:8];
         8'h62:   reg_byte = conv_val[CH_V][7:0];
         8'h63:   reg_byte = conv_val[CH_V][15:8];
         8'h77:   reg_byte = status_b;
         8'h78:   reg_byte = DEV_ID[7:0];
         8'h80:   reg_byte = cyc16[7:0];
         8'h81:   reg_byte = cyc16[15:8];
         8'h82:   reg_byte = DEV_ID[15:8];
         8'h83:   reg_byte = DEV_ID[23:16];
         default: reg_byte = 8'hFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_OPC;
         kind_q    <= XK_SP_RD;
         pend_q    <= NV_CP1;
         addr_q    <= '0;
         lock_q    <= 1'b0;
         cyc_q     <= '0;
         rd_vld_o  <= 1'b0;
         rd_byte_o <= 8'hFF;
         conv_go_q <= '0;
         for (int i = 0; i < SP_BYTES; i++) sp_q[i] <= '0;
         for (int i = 0; i < PG_BYTES; i++) begin
            nv1_q[i] <= '0;
            nv2_q[i] <= '0;
            ram_q[i] <= '0;
         end
      end else begin
         rd_vld_o  <= rd_req_i;
         rd_byte_o <= 8'hFF;
         conv_go_q <= conv_go & ~conv_busy;

         if (nv_done) begin
            case (pend_q)
               NV_CP1: for (int i = 0; i < PG_BYTES; i++)
                          if (!(lock_q && lk_mask[i])) nv1_q[i] <= sp_q[i];
               NV_CP2: for (int i = 0; i < PG_BYTES; i++)
                          nv2_q[i] <= sp_q[PG_BYTES + i];
               NV_LOCK:   lock_q <= 1'b1;
               NV_UNLOCK: lock_q <= 1'b0;
               NV_CCLR:   cyc_q  <= '0;
               default:   cyc_q  <= cyc_q + CNT_W'(1);
            endcase
         end

         if (bus_rst_i) begin
            state_q <= ST_OPC;
         end else begin
            case (state_q)
               ST_OPC: if (rx_vld_i) begin
                  state_q <= ST_HALT;
                  case (rx_byte_i)
                     OPC_RD_SP:  begin kind_q <= XK_SP_RD;  state_q <= ST_ADDR; end
                     OPC_WR_SP:  begin kind_q <= XK_SP_WR;  state_q <= ST_ADDR; end
                     OPC_RD_REG: begin kind_q <= XK_REG_RD; state_q <= ST_ADDR; end
                     OPC_SP1_NV1: if (nv_start) pend_q <= NV_CP1;
                     OPC_SP2_NV2: if (nv_start) pend_q <= NV_CP2;
                     OPC_LOCK:    if (nv_start) pend_q <= NV_LOCK;
                     OPC_UNLOCK:  if (nv_start) pend_q <= NV_UNLOCK;
                     OPC_CNT_CLR: if (nv_start) pend_q <= NV_CCLR;
                     OPC_CNT_INC: if (nv_start) pend_q <= NV_CINC;
                     OPC_NV1_SP1: for (int i = 0; i < PG_BYTES; i++)
                                     if (!(lock_q && lk_mask[i])) sp_q[i] <= nv1_q[i];
                     OPC_NV2_SP2: for (int i = 0; i < PG_BYTES; i++)
                                     sp_q[PG_BYTES + i] <= nv2_q[i];
                     OPC_RAM_SP3: for (int i = 0; i < PG_BYTES; i++)
                                     sp_q[2*PG_BYTES + i] <= ram_q[i];
                     OPC_SP3_RAM: for (int i = 0; i < PG_BYTES; i++)
                                     ram_q[i] <= sp_q[2*PG_BYTES + i];
                     default: ;
                  endcase
               end
               ST_ADDR: if (rx_vld_i) begin
                  addr_q <= rx_byte_i;
                  if (kind_q == XK_REG_RD) state_q <= reg_addr_ok(rx_byte_i) ? ST_XFER : ST_HALT;
                  else                     state_q <= sp_addr_ok(rx_byte_i)  ? ST_XFER : ST_HALT;
               end
               ST_XFER: begin
                  if (kind_q == XK_SP_RD && rd_req_i) begin
                     rd_byte_o <= sp_q[addr_q[6:0]];
                     addr_q    <= addr_nx;
                     if (!sp_addr_ok(addr_nx)) state_q <= ST_HALT;
                  end else if (kind_q == XK_SP_WR && rx_vld_i) begin
                     if (!(lock_q && addr_q < 8'(LOCK_BYTES))) sp_q[addr_q[6:0]] <= rx_byte_i;
                     addr_q <= addr_nx;
                     if (!sp_addr_ok(addr_nx)) state_q <= ST_HALT;
                  end else if (kind_q == XK_REG_RD && rd_req_i) begin
                     rd_byte_o <= reg_byte;
                     addr_q    <= addr_nx;
                     if (!reg_addr_ok(addr_nx)) state_q <= ST_HALT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_i |=> rd_vld_o);
   // R2
   halt_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && rd_req_i) |=> rd_byte_o == 8'hFF);
   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && LOCK_BYTES > 0) |=> ($stable(sp_q[0]) && $stable(nv1_q[0])));
   // R7
   cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nv_done |=> $stable(cyc_q));
   // R9
   vgo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_busy_o) |-> v_conv_go_o);
   // R9
   tgo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t_busy_o) |-> t_conv_go_o);
endmodule

// File: tb/bm_cmd_engine_bench.sv
`timescale 1ns/1ps
module bm_cmd_engine_bench;
   localparam int          D   = 12;
   localparam int          LKB = 24;
   localparam logic [23:0] ID  = 24'h5A3C96;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_rst = 1'b0, rx_vld = 1'b0, rd_req = 1'b0;
   logic [7:0] rx_byte = '0;
   logic rd_vld, v_go, t_go, nvb, vb, tb;
   logic [7:0] rd_byte;
   logic v_done = 1'b0, t_done = 1'b0;
   logic [15:0] v_data = '0, t_data = '0;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   bm_cmd_engine #(.NV_DELAY(D), .LOCK_BYTES(LKB), .CNT_W(16), .DEV_ID(ID)) u_bm_cmd_engine (
      .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
      .rd_req_i(rd_req), .rd_vld_o(rd_vld), .rd_byte_o(rd_byte),
      .v_conv_go_o(v_go), .v_conv_done_i(v_done), .v_conv_data_i(v_data),
      .t_conv_go_o(t_go), .t_conv_done_i(t_done), .t_conv_data_i(t_data),
      .nv_busy_o(nvb), .v_busy_o(vb), .t_busy_o(tb));

   function automatic logic [7:0] pat(input int seed, input int a);
      return 8'((a * seed + 8'h35) & 8'hFF);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_vld = 1'b1; rx_byte = b;
      @(negedge clk); rx_vld = 1'b0;
   endtask

   task automatic brst();
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v, output logic vld);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0; v = rd_byte; vld = rd_vld;
   endtask

   task automatic cmd(input logic [7:0] op);
      brst(); send(op);
   endtask

   task automatic nv_wait();
      repeat (D + 2) @(negedge clk);
   endtask

   task automatic rreg(input logic [7:0] a, output logic [7:0] v);
      logic vl;
      brst(); send(8'hB2); send(a); rd(v, vl);
   endtask

   task automatic wr_range(input int a0, input int n, input int seed);
      brst(); send(8'h17); send(8'(a0));
      for (int i = 0; i < n; i++) send(pat(seed, a0 + i));
   endtask

   task automatic rd_check(input string tag, input int a0, input int n, input int seed, input int lock_seed);
      logic [7:0] v; logic vl;
      brst(); send(8'h11); send(8'(a0));
      for (int i = 0; i < n; i++) begin
         rd(v, vl);
         if (lock_seed != 0 && (a0 + i) < LKB) chk(tag, v, pat(lock_seed, a0 + i));
         else                                  chk(tag, v, pat(seed, a0 + i));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got %0d exp 0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] v, v2; logic vl;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 flags", {nvb, vb, tb}, 3'b000);
      rreg(8'h77, v); chk("R11 status", v, 8'h00);
      rreg(8'h80, v); chk("R11 counter", v, 8'h00);
      brst(); send(8'h11); send(8'h00); rd(v, vl); chk("R11 sp zero", v, 8'h00);

      // R1 full sweeps with two patterns
      wr_range(0, 96, 3);   rd_check("R1 sweep3", 0, 96, 3, 0);
      wr_range(0, 96, 5);   rd_check("R1 sweep5", 0, 96, 5, 0);
      rd_check("R1 mid start", 8'h45, 3, 5, 0);

      // R2 increment past end and bad start
      brst(); send(8'h11); send(8'h5E);
      rd(v, vl); chk("R2 5E", v, pat(5, 8'h5E));
      rd(v, vl); chk("R2 5F", v, pat(5, 8'h5F));
      rd(v, vl); chk("R2 past end FF", v, 8'hFF);
      brst(); send(8'h17); send(8'h5F); send(8'h11); send(8'h22); send(8'h33);
      rd_check("R2 write stop", 0, 3, 5, 0);
      brst(); send(8'h11); send(8'h5F); rd(v, vl); chk("R2 last written", v, 8'h11);
      wr_range(8'h5F, 1, 5);
      brst(); send(8'h11); send(8'h60); rd(v, vl); chk("R2 bad start", v, 8'hFF);
      brst(); send(8'hB2); send(8'h64); rd(v, vl); chk("R2 bad reg", v, 8'hFF);
      brst(); send(8'hB2); send(8'h83); rd(v, vl); chk("R6 id hi", v, ID[23:16]);
      rd(v, vl); chk("R2 reg past end", v, 8'hFF);

      // R3 copy page1 to NV1, busy width
      cmd(8'h22);
      chk("R3 nvb rises", nvb, 1'b1);
      repeat (D - 1) @(negedge clk); chk("R3 nvb last", nvb, 1'b1);
      @(negedge clk); chk("R3 nvb falls", nvb, 1'b0);
      wr_range(0, 32, 9); rd_check("R3 overwrite", 0, 32, 9, 0);
      cmd(8'h71); rd_check("R3 R4 nv1 back", 0, 32, 5, 0);
      cmd(8'h25); nv_wait();
      wr_range(32, 32, 9); cmd(8'h77); rd_check("R3 R4 nv2 back", 32, 32, 5, 0);

      // R4 SRAM
      cmd(8'h28); chk("R4 no nvb", nvb, 1'b0);
      wr_range(64, 32, 9); cmd(8'h7A); rd_check("R4 sram back", 64, 32, 5, 0);

      // R7 R8 counter
      cmd(8'hB5); cmd(8'hB5); nv_wait();
      rreg(8'h80, v); chk("R8 ignored while busy", v, 8'h01);
      cmd(8'hB5); nv_wait();
      rreg(8'h80, v); rreg(8'h81, v2); chk("R7 inc", {v2, v}, 16'h0002);
      cmd(8'hB8); nv_wait();
      rreg(8'h80, v); chk("R7 clear", v, 8'h00);

      // R5 lock
      wr_range(0, 32, 11); cmd(8'h22); nv_wait();
      cmd(8'h43); chk("R5 nvb lock", nvb, 1'b1);
      cmd(8'h44); nv_wait();
      rreg(8'h77, v); chk("R8 unlock ignored", v, 8'h08);
      wr_range(0, 32, 13); rd_check("R5 locked write", 0, 32, 13, 11);
      cmd(8'h71); rd_check("R5 locked copy", 0, 32, 11, 0);
      cmd(8'h44); nv_wait();
      rreg(8'h77, v); chk("R5 unlocked", v, 8'h00);
      wr_range(0, 32, 13); rd_check("R5 after unlock", 0, 32, 13, 0);

      // R6 identity
      rreg(8'h78, v); chk("R6 id lo", v, ID[7:0]);
      rreg(8'h82, v); chk("R6 id mid", v, ID[15:8]);

      // R9 conversions
      cmd(8'hB4); chk("R9 vgo", {v_go, vb}, 2'b11);
      @(negedge clk); chk("R9 vgo pulse", v_go, 1'b0);
      rreg(8'h77, v); chk("R9 status adb", v, 8'h02);
      @(negedge clk); v_done = 1'b1; v_data = 16'hBEEF;
      @(negedge clk); v_done = 1'b0; chk("R9 v clear", vb, 1'b0);
      brst(); send(8'hB2); send(8'h62); rd(v, vl); rd(v2, vl);
      chk("R9 v data", {v2, v}, 16'hBEEF);
      cmd(8'hD2); chk("R9 tgo", {t_go, tb}, 2'b11);
      @(negedge clk); t_done = 1'b1; t_data = 16'h1234;
      @(negedge clk); t_done = 1'b0; chk("R9 t clear", tb, 1'b0);
      brst(); send(8'hB2); send(8'h60); rd(v, vl); rd(v2, vl);
      chk("R6 R9 t data", {v2, v}, 16'h1234);

      // R10 unknown opcode
      brst(); send(8'h55); send(8'h17); send(8'h00); send(8'hAA);
      rd(v, vl); chk("R10 halted read", v, 8'hFF);
      rd_check("R10 no write", 0, 2, 13, 0);

      // R12 read answered outside a transaction
      cmd(8'h28); rd(v, vl); chk("R12 vld and FF", {vl, v}, {1'b1, 8'hFF});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule